// File: doc/BRIEF.md
# MESI snooping cache-state controller

This block holds the four-state coherence tag for every line of a small direct-mapped, write-back cache that sits on one shared bus with other caching agents. The processor side presents one read or write request at a time and holds it stable until the block reports completion together with hit or miss. A miss, an upgrade of a shared line, or the eviction of a dirty victim is turned into a bus request: a plain read, a read-for-ownership, an upgrade that invalidates the other copies, or a write-back. The request stays up until the bus answers. With the answer to its own read, the block samples the bus shared signal to decide whether the new line is installed exclusive-clean or shared.

A separate copy of the tags serves snooping, so lookups for the processor and lookups for the bus never compete for the same tag read. Each snooped transaction is checked against that copy. A matching line is downgraded or invalidated. The block tells the bus, one cycle later, whether the line was present, whether it still holds a copy after the snoop, and whether it must supply dirty data. The bus is assumed to carry one transaction at a time, so no snoop arrives while the block's own request is waiting for its answer. Line index is the low address bits and the tag is the remainder. The data arrays, arbitration and memory timing sit outside.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code I=00; the other codes are S=01, E=10, M=11), bus_req_valid, cpu_done, snoop_hit, snoop_flush and snoop_shared are low, and the first read of any address misses.
- R2: A read that misses issues a bus read (op code 01) at the request address; when the answer arrives the block completes the read as a miss. It installs the line as E if bus_shared_in was low in the answer cycle and as S if it was high. A later write to an E line needs no bus traffic, while a write to an S line issues an upgrade.
- R3: A read hit on an M, E or S line, and a write hit on an M or E line, complete with cpu_hit high and no bus request; a write to an E line leaves it in M.
- R4: A write hit on an S line issues an upgrade (op code 11) at the request address, holds the request with op and address stable until bus_resp_valid, then completes as a hit with the line in M.
- R5: A write miss issues a read-for-ownership (op code 10) at the request address and installs the line in M; it completes as a miss.
- R6: A miss whose victim line is in M first issues a write-back (op code 00) carrying the victim's address, and only after its answer issues the fill for the new address.
- R7: A snooped read (snoop op 01) that matches a valid line raises snoop_hit and snoop_shared; a matching M line also raises snoop_flush; M and E lines become S.
- R8: A snooped read-for-ownership (10) or invalidate (11) that matches a valid line raises snoop_hit, raises snoop_flush if the line was M, keeps snoop_shared low, and leaves the line Invalid.
- R9: A snoop with op 00 or with no matching valid line leaves the line state unchanged and drives snoop_hit, snoop_flush and snoop_shared low.
- R10: When a snoop and a processor request are presented in the same cycle, the snoop is served first: cpu_done stays low in that cycle and the processor request is served afterwards against the state the snoop left.
- R11: The snoop response outputs are registered: they appear in the cycle after snoop_valid and are low in the cycle of the snoop itself when no snoop was served in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present, held until cpu_done |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_done | output | 1 | Request completes in this cycle |
| cpu_hit | output | 1 | With cpu_done: the request hit |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_op | output | 2 | 00 write-back, 01 read, 10 read-for-ownership, 11 upgrade |
| bus_req_addr | output | ADDR_W | Line address of the bus request |
| bus_resp_valid | input | 1 | Bus answers the pending request in this cycle |
| bus_shared_in | input | 1 | Another cache holds the line; sampled with the answer |
| snoop_valid | input | 1 | Another agent's bus transaction is visible |
| snoop_op | input | 2 | 00 write-back (ignored), 01 read, 10 read-for-ownership, 11 invalidate |
| snoop_addr | input | ADDR_W | Line address of the snooped transaction |
| snoop_hit | output | 1 | Previous-cycle snoop matched a valid line |
| snoop_flush | output | 1 | Previous-cycle snoop requires dirty data from this cache |
| snoop_shared | output | 1 | This cache keeps a copy after the previous-cycle read snoop |

## Verification
The snoop path and the processor path can both want the line state in the same cycle, and the snoop must win. The bench provokes this by presenting a write to a line held in M together with a read-for-ownership snoop of the same line. It judges the result by seeing cpu_done stay low in that cycle, by seeing the snoop answered with a flush, and then by seeing the write served as a miss that issues its own read-for-ownership. Ahead of that, a walked table of processor and snoop transactions establishes each state, and later accesses expose it through bus traffic and snoop responses.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } mesi_t;

  typedef enum logic [1:0] {
    BUS_WB  = 2'b00,
    BUS_RD  = 2'b01,
    BUS_RFO = 2'b10,
    BUS_UPG = 2'b11
  } busop_t;

  typedef enum logic [1:0] {
    SNP_NONE = 2'b00,
    SNP_RD   = 2'b01,
    SNP_RFO  = 2'b10,
    SNP_INV  = 2'b11
  } snpop_t;

  typedef enum logic [1:0] {
    CS_IDLE = 2'b00,
    CS_WBK  = 2'b01,
    CS_FILL = 2'b10,
    CS_UPG  = 2'b11
  } ctl_st_t;
endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic [TAG_W-1:0] cpu_tag,
  output mesi_t            cpu_state,
  input  logic             ctl_we,
  input  mesi_t            ctl_state,
  input  logic             fill_we,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [TAG_W-1:0] snp_tag,
  output mesi_t            snp_state,
  input  logic             snp_we,
  input  mesi_t            snp_state_nxt
);
  logic [LINES-1:0][1:0]       state_all;
  logic [LINES-1:0][TAG_W-1:0] ptag_all;
  logic [LINES-1:0][TAG_W-1:0] stag_all;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]       st_q;
    logic [1:0]       st_d;
    logic             st_en;
    logic [TAG_W-1:0] ptag_q;
    logic [TAG_W-1:0] stag_q;
    logic             tag_en;

    // snoop write wins over a processor-side write to the same line
    always_comb begin
      st_en = 1'b0;
      st_d  = st_q;
      if (snp_we && (snp_idx == IDX_W'(g))) begin
        st_en = 1'b1;
        st_d  = snp_state_nxt;
      end else if (ctl_we && (cpu_idx == IDX_W'(g))) begin
        st_en = 1'b1;
        st_d  = ctl_state;
      end
    end

    assign tag_en = fill_we && (cpu_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= ST_I;
      end else if (st_en) begin
        st_q <= st_d;
      end
    end

    // both tag copies are loaded together on every fill
    always_ff @(posedge clk) begin
      if (tag_en) begin
        ptag_q <= fill_tag;
        stag_q <= fill_tag;
      end
    end

    assign state_all[g] = st_q;
    assign ptag_all[g]  = ptag_q;
    assign stag_all[g]  = stag_q;
  end

  assign cpu_tag   = ptag_all[cpu_idx];
  assign cpu_state = mesi_t'(state_all[cpu_idx]);
  assign snp_tag   = stag_all[snp_idx];
  assign snp_state = mesi_t'(state_all[snp_idx]);
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  input  mesi_t             snp_state,
  output logic              snp_we,
  output mesi_t             snp_state_nxt,
  output logic              snoop_hit,
  output logic              snoop_flush,
  output logic              snoop_shared
);
  logic match;
  logic hit_d, flush_d, shared_d;

  assign snp_idx = snoop_addr[IDX_W-1:0];

  always_comb begin
    match = snoop_valid && (snoop_op != SNP_NONE) &&
            (snp_state != ST_I) && (snp_tag == snoop_addr[ADDR_W-1:IDX_W]);
    snp_we        = match;
    snp_state_nxt = (snoop_op == SNP_RD) ? ST_S : ST_I;
    hit_d         = match;
    flush_d       = match && (snp_state == ST_M);
    shared_d      = match && (snoop_op == SNP_RD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snoop_hit    <= 1'b0;
      snoop_flush  <= 1'b0;
      snoop_shared <= 1'b0;
    end else begin
      snoop_hit    <= hit_d;
      snoop_flush  <= flush_d;
      snoop_shared <= shared_d;
    end
  end

  // R7 R8: dirty data is only ever offered for a line that was present
  a_r7_flush_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_flush |-> snoop_hit);

  // R9 R11: no snoop in a cycle means no response in the next one
  a_r11_quiet_without_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_valid |=> !snoop_hit && !snoop_shared && !snoop_flush);
endmodule

// File: rtl/mesi_proc_ctrl.sv
module mesi_proc_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              snoop_busy,
  output logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  mesi_t             lk_state,
  output logic              ctl_we,
  output mesi_t             ctl_state,
  output logic              fill_we,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              cpu_done,
  output logic              cpu_hit,
  input  logic              bus_resp_valid,
  input  logic              bus_shared_in,
  output logic              bus_req_valid,
  output busop_t            bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr
);
  ctl_st_t           st_q, st_d;
  busop_t            op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              req_en;
  logic              tag_eq, hit;
  busop_t            fill_op;

  assign cpu_idx  = cpu_req_addr[IDX_W-1:0];
  assign fill_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign tag_eq   = (lk_tag == cpu_req_addr[ADDR_W-1:IDX_W]);
  assign hit      = tag_eq && (lk_state != ST_I);
  assign fill_op  = cpu_req_write ? BUS_RFO : BUS_RD;

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    addr_d    = addr_q;
    req_en    = 1'b0;
    ctl_we    = 1'b0;
    ctl_state = ST_I;
    fill_we   = 1'b0;
    cpu_done  = 1'b0;
    cpu_hit   = 1'b0;
    case (st_q)
      CS_IDLE: begin
        if (cpu_req_valid && !snoop_busy) begin
          if (hit) begin
            if (!cpu_req_write || (lk_state == ST_M)) begin
              cpu_done = 1'b1;
              cpu_hit  = 1'b1;
            end else if (lk_state == ST_E) begin
              ctl_we    = 1'b1;
              ctl_state = ST_M;
              cpu_done  = 1'b1;
              cpu_hit   = 1'b1;
            end else begin
              req_en = 1'b1;
              st_d   = CS_UPG;
              op_d   = BUS_UPG;
              addr_d = cpu_req_addr;
            end
          end else if (lk_state == ST_M) begin
            req_en = 1'b1;
            st_d   = CS_WBK;
            op_d   = BUS_WB;
            addr_d = {lk_tag, cpu_idx};
          end else begin
            req_en = 1'b1;
            st_d   = CS_FILL;
            op_d   = fill_op;
            addr_d = cpu_req_addr;
          end
        end
      end
      CS_WBK: begin
        if (bus_resp_valid) begin
          req_en    = 1'b1;
          ctl_we    = 1'b1;
          ctl_state = ST_I;
          st_d      = CS_FILL;
          op_d      = fill_op;
          addr_d    = cpu_req_addr;
        end
      end
      CS_FILL: begin
        if (bus_resp_valid) begin
          req_en    = 1'b1;
          st_d      = CS_IDLE;
          fill_we   = 1'b1;
          ctl_we    = 1'b1;
          ctl_state = cpu_req_write ? ST_M : (bus_shared_in ? ST_S : ST_E);
          cpu_done  = 1'b1;
        end
      end
      CS_UPG: begin
        if (bus_resp_valid) begin
          req_en    = 1'b1;
          st_d      = CS_IDLE;
          ctl_we    = 1'b1;
          ctl_state = ST_M;
          cpu_done  = 1'b1;
          cpu_hit   = 1'b1;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      op_q   <= BUS_RD;
      addr_q <= '0;
    end else if (req_en) begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
    end
  end

  assign bus_req_valid = (st_q != CS_IDLE);
  assign bus_req_op    = op_q;
  assign bus_req_addr  = addr_q;

  // R4: an unanswered request keeps its op and address
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_resp_valid |=>
      bus_req_valid && $stable(bus_req_op) && $stable(bus_req_addr));

  // R6: an answered write-back is always followed by the fill
  a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && (bus_req_op == BUS_WB) && bus_resp_valid |=>
      bus_req_valid && (bus_req_op != BUS_WB));

  // R2 R5: an answered fill completes the request as a miss
  a_r5_fill_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_resp_valid &&
      ((bus_req_op == BUS_RD) || (bus_req_op == BUS_RFO)) |-> cpu_done && !cpu_hit);

  // R10: a snoop in the cycle blocks processor completion
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_busy && !bus_req_valid |-> !cpu_done);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_resp_valid,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_hit,
  output logic              snoop_flush,
  output logic              snoop_shared
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag, fill_tag;
  mesi_t            cpu_state, snp_state, ctl_state, snp_state_nxt;
  logic             ctl_we, fill_we, snp_we;
  busop_t           op_w;

  mesi_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst_n(rst_sync_q),
    .cpu_idx(cpu_idx), .cpu_tag(cpu_tag), .cpu_state(cpu_state),
    .ctl_we(ctl_we), .ctl_state(ctl_state),
    .fill_we(fill_we), .fill_tag(fill_tag),
    .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_state(snp_state),
    .snp_we(snp_we), .snp_state_nxt(snp_state_nxt)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) snoop_i (
    .clk(clk), .rst_n(rst_sync_q),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_addr(snoop_addr),
    .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_state(snp_state),
    .snp_we(snp_we), .snp_state_nxt(snp_state_nxt),
    .snoop_hit(snoop_hit), .snoop_flush(snoop_flush), .snoop_shared(snoop_shared)
  );

  mesi_proc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_q),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .snoop_busy(snoop_valid),
    .cpu_idx(cpu_idx), .lk_tag(cpu_tag), .lk_state(cpu_state),
    .ctl_we(ctl_we), .ctl_state(ctl_state),
    .fill_we(fill_we), .fill_tag(fill_tag),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_resp_valid(bus_resp_valid), .bus_shared_in(bus_shared_in),
    .bus_req_valid(bus_req_valid), .bus_req_op(op_w), .bus_req_addr(bus_req_addr)
  );

  assign bus_req_op = op_w;
endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req_valid, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic          cpu_done, cpu_hit;
  logic          bus_req_valid;
  logic [1:0]    bus_req_op;
  logic [AW-1:0] bus_req_addr;
  logic          bus_resp_valid, bus_shared_in;
  logic          snoop_valid;
  logic [1:0]    snoop_op;
  logic [AW-1:0] snoop_addr;
  logic          snoop_hit, snoop_flush, snoop_shared;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
    .bus_req_addr(bus_req_addr), .bus_resp_valid(bus_resp_valid),
    .bus_shared_in(bus_shared_in), .snoop_valid(snoop_valid),
    .snoop_op(snoop_op), .snoop_addr(snoop_addr), .snoop_hit(snoop_hit),
    .snoop_flush(snoop_flush), .snoop_shared(snoop_shared)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done_all = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line addresses: index = addr[2:0], tag = addr[15:3]
  localparam logic [15:0] LA = 16'h0010;
  localparam logic [15:0] LB = 16'h0018;
  localparam logic [15:0] LC = 16'h0021;
  localparam logic [15:0] LD = 16'h0032;

  typedef struct packed {
    logic        snp;    // 1 = snoop row
    logic [1:0]  op;     // cpu: bit0 write; snoop: op code
    logic [15:0] addr;
    logic        sh;     // bus_shared_in for answers
    logic        hit;
    logic [1:0]  n;      // bus ops expected
    logic [1:0]  op0;
    logic [1:0]  op1;
    logic [15:0] a0;
    logic        fl;
    logic        shr;
    logic        shit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, LA, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, LA, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 miss -> E
    '{1'b0, 2'd0, LA, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, LA, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 read E
    '{1'b0, 2'd1, LA, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, LA, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 silent E->M
    '{1'b0, 2'd1, LA, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, LA, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 write M
    '{1'b0, 2'd0, LB, 1'b1, 1'b0, 2'd2, 2'd0, 2'd1, LA, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 WB then RD
    '{1'b0, 2'd0, LB, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, LB, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 read S
    '{1'b0, 2'd1, LB, 1'b0, 1'b1, 2'd1, 2'd3, 2'd0, LB, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 S upgrade
    '{1'b1, 2'd1, LB, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LB, 1'b1, 1'b1, 1'b1, 4'd7}, // R7 M read snoop
    '{1'b0, 2'd0, LB, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, LB, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 still present
    '{1'b1, 2'd3, LB, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LB, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 inv S
    '{1'b0, 2'd1, LB, 1'b0, 1'b0, 2'd1, 2'd2, 2'd0, LB, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 write miss
    '{1'b1, 2'd2, LB, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LB, 1'b1, 1'b0, 1'b1, 4'd8}, // R8 rfo on M
    '{1'b0, 2'd0, LC, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, LC, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 C -> E
    '{1'b1, 2'd1, LC, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LC, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 E -> S
    '{1'b0, 2'd1, LC, 1'b0, 1'b1, 2'd1, 2'd3, 2'd0, LC, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 proves S
    '{1'b1, 2'd1, LD, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LD, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 no match
    '{1'b1, 2'd0, LC, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LC, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 op 00
    '{1'b1, 2'd1, LC, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LC, 1'b1, 1'b1, 1'b1, 4'd9}, // R9 still M
    '{1'b0, 2'd0, LD, 1'b1, 1'b0, 2'd1, 2'd1, 2'd0, LD, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 shared -> S
    '{1'b0, 2'd1, LD, 1'b0, 1'b1, 2'd1, 2'd3, 2'd0, LD, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 proves S
    '{1'b1, 2'd3, LC, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, LC, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 inv S
    '{1'b0, 2'd0, LC, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, LC, 1'b0, 1'b0, 1'b0, 4'd8}  // R8 now I
  };

  task automatic cpu_op(input logic wr, input logic [15:0] a, input logic sh,
                        output logic hit, output int n, output logic [1:0] o0,
                        output logic [1:0] o1, output logic [15:0] a0);
    bit fin = 0;
    int guard = 0;
    n = 0; hit = 0; o0 = 0; o1 = 0; a0 = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a;
    while (!fin && guard < 60) begin
      guard++;
      #1;
      if (cpu_done) begin
        hit = cpu_hit; fin = 1;
      end else if (bus_req_valid) begin
        if (n == 0) begin o0 = bus_req_op; a0 = bus_req_addr; end
        else o1 = bus_req_op;
        n++;
        bus_resp_valid = 1; bus_shared_in = sh;
        #1;
        if (cpu_done) begin hit = cpu_hit; fin = 1; end
      end
      @(posedge clk); #1;
      bus_resp_valid = 0; bus_shared_in = 0;
      if (fin) cpu_req_valid = 0;
      else @(negedge clk);
    end
    if (!fin) check(0, "cpu request never completed", 0, 1);
  endtask

  task automatic snp_op(input logic [1:0] op, input logic [15:0] a,
                        output logic h, output logic f, output logic s);
    @(negedge clk);
    snoop_valid = 1; snoop_op = op; snoop_addr = a;
    @(posedge clk); #1;
    snoop_valid = 0; snoop_op = 0;
    h = snoop_hit; f = snoop_flush; s = snoop_shared;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_all) begin
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic h, f, s, hit;
    logic [1:0] o0, o1;
    logic [15:0] a0;
    int n;
    rst_n = 0; cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = 0;
    bus_resp_valid = 0; bus_shared_in = 0;
    snoop_valid = 0; snoop_op = 0; snoop_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state at the ports
    check(bus_req_valid == 0, "R1 bus_req_valid", bus_req_valid, 0);
    check(cpu_done == 0, "R1 cpu_done", cpu_done, 0);
    check({snoop_hit, snoop_flush, snoop_shared} == 3'b000, "R1 snoop outputs",
          {snoop_hit, snoop_flush, snoop_shared}, 0);
    // R1 all lines start Invalid: a snoop read finds nothing
    snp_op(2'd1, LA, h, f, s);
    check(h == 0, "R1 snoop after reset hit", h, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.snp) begin
        snp_op(v.op, v.addr, h, f, s);
        check(h == v.shit, $sformatf("R%0d row %0d snoop_hit", v.req, i), h, v.shit);
        check(f == v.fl, $sformatf("R%0d row %0d snoop_flush", v.req, i), f, v.fl);
        check(s == v.shr, $sformatf("R%0d row %0d snoop_shared", v.req, i), s, v.shr);
      end else begin
        cpu_op(v.op[0], v.addr, v.sh, hit, n, o0, o1, a0);
        check(hit == v.hit, $sformatf("R%0d row %0d cpu_hit", v.req, i), hit, v.hit);
        check(n == int'(v.n), $sformatf("R%0d row %0d bus op count", v.req, i), n, v.n);
        if (v.n > 0) begin
          check(o0 == v.op0, $sformatf("R%0d row %0d first op", v.req, i), o0, v.op0);
          check(a0 == v.a0, $sformatf("R%0d row %0d first addr", v.req, i), a0, v.a0);
        end
        if (v.n > 1)
          check(o1 == v.op1, $sformatf("R%0d row %0d second op", v.req, i), o1, v.op1);
      end
    end

    // R11: response is registered (C is E after the last row)
    @(negedge clk);
    snoop_valid = 1; snoop_op = 2'd1; snoop_addr = LC;
    #1;
    check(snoop_hit == 0, "R11 no response in snoop cycle", snoop_hit, 0);
    @(posedge clk); #1;
    snoop_valid = 0; snoop_op = 0;
    check(snoop_hit == 1 && snoop_shared == 1 && snoop_flush == 0,
          "R11 response next cycle", {snoop_hit, snoop_shared, snoop_flush}, 3'b110);

    // R10: D is M; write D and rfo snoop of D in the same cycle
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = LD;
    snoop_valid = 1; snoop_op = 2'd2; snoop_addr = LD;
    #1;
    check(cpu_done == 0, "R10 cpu held off by snoop", cpu_done, 0);
    @(posedge clk); #1;
    snoop_valid = 0; snoop_op = 0;
    check(snoop_hit == 1 && snoop_flush == 1, "R10 snoop served first flush",
          {snoop_hit, snoop_flush}, 2'b11);
    cpu_op(1'b1, LD, 1'b0, hit, n, o0, o1, a0);
    check(hit == 0, "R10 write after snoop misses", hit, 0);
    check(n == 1 && o0 == 2'd2, "R10 write after snoop issues rfo", o0, 2);

    done_all = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule